// File: doc/BRIEF.md
# Multi-drop address frame filter

This block sits between a serial receiver and its receive buffer on a bus where many nodes share one line. Each completed character arrives with its data bits, the first stop bit and the current character length. From these the block works out the frame-type bit: in 9-bit mode it is the ninth data bit, and in 5- to 8-bit modes it is the first stop bit. A type of 1 marks an address frame and a type of 0 marks a data frame.

A single filter-enable bit drives a two-state machine. In `ST_ADDR_ONLY` (filter on), only address frames raise the buffer write strobe and data frames are dropped. In `ST_PASS_ALL` (filter off), every frame is written and its type bit goes along with it. The host moves between the states with a control write (transition `HOST_SET` to `ST_ADDR_ONLY`, `HOST_CLEAR` to `ST_PASS_ALL`). When address compare is enabled, an address frame that matches the node's own address takes the transition `AUTO_MATCH` from `ST_ADDR_ONLY` to `ST_PASS_ALL`. A node is therefore selected by the master and then listens to the data that follows. The host sets the filter again once the last data frame has arrived. The block has no transmit-side ports and does not touch transmission.

Top module: `mdf_frame_filter`

## Requirements
- R1: After reset the state is `ST_PASS_ALL` (`filt_en_o` = 0) and `buf_we_o` is 0.
- R2: When `char_len_i` = 9 the type bit is `frm_data_i[8]` and `frm_stop_i` is ignored. When `char_len_i` is 5 to 8 the type bit is `frm_stop_i`.
- R3: In `ST_ADDR_ONLY`, a frame with type bit 0 produces no `buf_we_o` pulse.
- R4: A frame with type bit 1 is always written. `buf_we_o` is high for one cycle, in the cycle after the clock edge that samples `frm_valid_i`, and `buf_type_o` = 1.
- R5: In `ST_PASS_ALL` every frame is written, and `buf_type_o` carries its type bit.
- R6: `buf_data_o` holds the received bits below `char_len_i`. Bits at and above `char_len_i` are forced to 0.
- R7: With `cmp_en_i` = 1 in `ST_ADDR_ONLY`, an address frame whose address equals `own_addr_i` moves the state to `ST_PASS_ALL` on the same edge that writes the frame. A non-matching address leaves the state unchanged.
- R8: The address compare covers bits 0 to min(`char_len_i`, 8) - 1 of the data.
- R9: `ctl_we_i` loads `filt_en_o` from `ctl_wdata_i` (1 = `ST_ADDR_ONLY`). A control write takes priority over `AUTO_MATCH` on the same edge.
- R10: The accept decision for a frame uses the state held before its sampling edge. A control write on that same edge affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_len_i | input | 4 | Character length, 5 to 9 |
| frm_valid_i | input | 1 | One-cycle strobe for a completed frame |
| frm_data_i | input | 9 | Received data bits, LSB first |
| frm_stop_i | input | 1 | First stop bit of the frame |
| ctl_we_i | input | 1 | Host write to the filter-enable bit |
| ctl_wdata_i | input | 1 | Value written to the filter-enable bit |
| cmp_en_i | input | 1 | Enable the own-address compare |
| own_addr_i | input | 8 | Node address |
| buf_we_o | output | 1 | Receive buffer write strobe |
| buf_data_o | output | 9 | Data written to the buffer |
| buf_type_o | output | 1 | Frame-type bit written with the data |
| filt_en_o | output | 1 | Current filter-enable state |

## Verification
A wrong state shows up at the ports on the very next frame. A node left in `ST_PASS_ALL` by mistake writes a data frame it should drop. A node stuck in `ST_ADDR_ONLY` never writes the data that follows its own address. Either error appears on `buf_we_o` one cycle after the frame strobe, and on `filt_en_o` one cycle after the edge that should have changed it. The bench therefore pairs every state change with a data frame sent right after it. It also sends frames whose type comes from the source that must be ignored in the current character length.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
    localparam int MAX_W  = 9;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 4;

    typedef enum logic {
        ST_PASS_ALL  = 1'b0,
        ST_ADDR_ONLY = 1'b1
    } filt_state_e;
endpackage

// File: rtl/mdf_type_sel.sv
module mdf_type_sel #(
    parameter int MAX_W = 9,
    parameter int LEN_W = 4
) (
    input  logic [LEN_W-1:0] len_i,
    input  logic [MAX_W-1:0] data_i,
    input  logic             stop_i,
    output logic [MAX_W-1:0] data_o,
    output logic             type_o
);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_W);

    for (genvar i = 0; i < MAX_W; i++) begin : g_mask
        localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
        assign data_o[i] = data_i[i] & (IDX < len_i);
    end

    always_comb begin
        if (len_i == FULL_LEN) type_o = data_i[MAX_W-1];
        else                   type_o = stop_i;
    end
endmodule

// File: rtl/mdf_addr_match.sv
module mdf_addr_match #(
    parameter int MAX_W  = 9,
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 4
) (
    input  logic [LEN_W-1:0]  len_i,
    input  logic [MAX_W-1:0]  data_i,
    input  logic [ADDR_W-1:0] own_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
        localparam logic [LEN_W-1:0] IDX = LEN_W'(i);
        assign bit_ok[i] = (data_i[i] == own_i[i]) | ~(IDX < len_i);
    end

    assign hit_o = &bit_ok;
endmodule

// File: rtl/mdf_filter_ctrl.sv
module mdf_filter_ctrl
    import mdf_pkg::*;
#(
    parameter int   MAX_W        = 9,
    parameter logic RESET_FILTER = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [MAX_W-1:0] data_i,
    input  logic             type_i,
    input  logic             hit_i,
    input  logic             cmp_en_i,
    input  logic             ctl_we_i,
    input  logic             ctl_wdata_i,
    output logic             buf_we_o,
    output logic [MAX_W-1:0] buf_data_o,
    output logic             buf_type_o,
    output logic             filt_en_o
);
    localparam filt_state_e RST_STATE = RESET_FILTER ? ST_ADDR_ONLY : ST_PASS_ALL;

    filt_state_e state_q, state_d;
    logic        accept;
    logic        auto_clr;

    always_comb begin
        accept   = 1'b0;
        auto_clr = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_PASS_ALL: begin
                accept = valid_i;
            end
            ST_ADDR_ONLY: begin
                accept   = valid_i & type_i;
                auto_clr = valid_i & type_i & cmp_en_i & hit_i;
                if (auto_clr) state_d = ST_PASS_ALL;
            end
            default: state_d = RST_STATE;
        endcase
        if (ctl_we_i) state_d = ctl_wdata_i ? ST_ADDR_ONLY : ST_PASS_ALL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we_o   <= 1'b0;
            buf_data_o <= '0;
            buf_type_o <= 1'b0;
        end else begin
            buf_we_o <= accept;
            if (accept) begin
                buf_data_o <= data_i;
                buf_type_o <= type_i;
            end
        end
    end

    assign filt_en_o = (state_q == ST_ADDR_ONLY);

    p_drop_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en_o && valid_i && !type_i) |=> !buf_we_o);
    p_addr_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && type_i) |=> (buf_we_o && buf_type_o));
    p_pass_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_en_o && valid_i) |=> buf_we_o);
    p_no_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !buf_we_o);
    p_auto_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we_i && filt_en_o && valid_i && type_i && cmp_en_i && hit_i) |=> !filt_en_o);
    p_host_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we_i |=> (filt_en_o == $past(ctl_wdata_i)));
    p_hold_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_we_i && !(valid_i && type_i && cmp_en_i && hit_i)) |=> $stable(filt_en_o));
endmodule

// File: rtl/mdf_frame_filter.sv
module mdf_frame_filter
    import mdf_pkg::*;
#(
    parameter int   DATA_W       = MAX_W,
    parameter int   OWN_W        = ADDR_W,
    parameter int   CLEN_W       = LEN_W,
    parameter logic RESET_FILTER = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CLEN_W-1:0] char_len_i,
    input  logic              frm_valid_i,
    input  logic [DATA_W-1:0] frm_data_i,
    input  logic              frm_stop_i,
    input  logic              ctl_we_i,
    input  logic              ctl_wdata_i,
    input  logic              cmp_en_i,
    input  logic [OWN_W-1:0]  own_addr_i,
    output logic              buf_we_o,
    output logic [DATA_W-1:0] buf_data_o,
    output logic              buf_type_o,
    output logic              filt_en_o
);
    logic [DATA_W-1:0] data_m;
    logic              frm_type;
    logic              addr_hit;

    mdf_type_sel #(.MAX_W(DATA_W), .LEN_W(CLEN_W)) u_type (
        .len_i  (char_len_i),
        .data_i (frm_data_i),
        .stop_i (frm_stop_i),
        .data_o (data_m),
        .type_o (frm_type)
    );

    mdf_addr_match #(.MAX_W(DATA_W), .ADDR_W(OWN_W), .LEN_W(CLEN_W)) u_match (
        .len_i  (char_len_i),
        .data_i (data_m),
        .own_i  (own_addr_i),
        .hit_o  (addr_hit)
    );

    mdf_filter_ctrl #(.MAX_W(DATA_W), .RESET_FILTER(RESET_FILTER)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (frm_valid_i),
        .data_i      (data_m),
        .type_i      (frm_type),
        .hit_i       (addr_hit),
        .cmp_en_i    (cmp_en_i),
        .ctl_we_i    (ctl_we_i),
        .ctl_wdata_i (ctl_wdata_i),
        .buf_we_o    (buf_we_o),
        .buf_data_o  (buf_data_o),
        .buf_type_o  (buf_type_o),
        .filt_en_o   (filt_en_o)
    );
endmodule

// File: tb/mdf_frame_filter_tb.sv
module mdf_frame_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] char_len_i = 4'd8;
    logic       frm_valid_i = 1'b0;
    logic [8:0] frm_data_i = '0;
    logic       frm_stop_i = 1'b0;
    logic       ctl_we_i = 1'b0;
    logic       ctl_wdata_i = 1'b0;
    logic       cmp_en_i = 1'b0;
    logic [7:0] own_addr_i = '0;
    logic       buf_we_o;
    logic [8:0] buf_data_o;
    logic       buf_type_o;
    logic       filt_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    mdf_frame_filter dut_i (
        .clk(clk), .rst_n(rst_n), .char_len_i(char_len_i),
        .frm_valid_i(frm_valid_i), .frm_data_i(frm_data_i), .frm_stop_i(frm_stop_i),
        .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .cmp_en_i(cmp_en_i),
        .own_addr_i(own_addr_i), .buf_we_o(buf_we_o), .buf_data_o(buf_data_o),
        .buf_type_o(buf_type_o), .filt_en_o(filt_en_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, sample at the next falling edge
    task automatic step(input logic v, input logic [3:0] len, input logic [8:0] d,
                        input logic s, input logic we, input logic wd);
        @(negedge clk);
        frm_valid_i = v; char_len_i = len; frm_data_i = d; frm_stop_i = s;
        ctl_we_i = we; ctl_wdata_i = wd;
        @(negedge clk);
        frm_valid_i = 1'b0; ctl_we_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 filt_en", filt_en_o, 0);
        chk("R1 buf_we", buf_we_o, 0);
    endtask

    task automatic t_pass_all;
        step(1, 4'd8, 9'h0A5, 1'b0, 0, 0);
        chk("R5 we", buf_we_o, 1);
        chk("R5 type", buf_type_o, 0);
        chk("R5 data", buf_data_o, 9'h0A5);
        step(1, 4'd9, 9'h13C, 1'b0, 0, 0);
        chk("R2 nine-bit type", buf_type_o, 1);
        chk("R5 data9", buf_data_o, 9'h13C);
        step(1, 4'd5, 9'h1FF, 1'b1, 0, 0);
        chk("R6 masked data", buf_data_o, 9'h01F);
        chk("R2 stop type", buf_type_o, 1);
        step(0, 4'd8, 9'h000, 1'b0, 0, 0);
        chk("R4 single pulse", buf_we_o, 0);
    endtask

    task automatic t_filter_on;
        step(0, 4'd8, 9'h000, 1'b0, 1, 1);
        chk("R9 set", filt_en_o, 1);
        step(1, 4'd8, 9'h055, 1'b0, 0, 0);
        chk("R3 data dropped", buf_we_o, 0);
        step(1, 4'd9, 9'h055, 1'b1, 0, 0);
        chk("R2 stop ignored in 9-bit", buf_we_o, 0);
        step(1, 4'd7, 9'h033, 1'b1, 0, 0);
        chk("R4 addr written", buf_we_o, 1);
        chk("R4 type", buf_type_o, 1);
        chk("R6 data7", buf_data_o, 9'h033);
        step(1, 4'd9, 9'h1AA, 1'b0, 0, 0);
        chk("R2 ninth bit address", buf_we_o, 1);
    endtask

    task automatic t_auto_match;
        cmp_en_i = 1'b1; own_addr_i = 8'h42;
        step(1, 4'd9, 9'h143, 1'b0, 0, 0);
        chk("R7 non-match written", buf_we_o, 1);
        chk("R7 non-match keeps filter", filt_en_o, 1);
        step(1, 4'd9, 9'h142, 1'b0, 0, 0);
        chk("R7 match written", buf_we_o, 1);
        chk("R7 match clears", filt_en_o, 0);
        step(1, 4'd9, 9'h011, 1'b0, 0, 0);
        chk("R5 data after select", buf_we_o, 1);
        chk("R5 data after select type", buf_type_o, 0);
    endtask

    task automatic t_short_compare;
        step(0, 4'd5, 9'h000, 1'b0, 1, 1);
        step(1, 4'd5, 9'h022, 1'b1, 0, 0);
        chk("R8 5-bit compare match", filt_en_o, 0);
        chk("R8 data", buf_data_o, 9'h002);
        step(0, 4'd5, 9'h000, 1'b0, 1, 1);
        step(1, 4'd5, 9'h003, 1'b1, 0, 0);
        chk("R8 5-bit compare miss", filt_en_o, 1);
    endtask

    task automatic t_priority;
        step(1, 4'd9, 9'h142, 1'b0, 1, 1);
        chk("R9 write beats match", filt_en_o, 1);
        chk("R9 frame still written", buf_we_o, 1);
        step(1, 4'd8, 9'h077, 1'b0, 1, 0);
        chk("R10 old state drops", buf_we_o, 0);
        chk("R9 clear", filt_en_o, 0);
        step(1, 4'd8, 9'h078, 1'b0, 0, 0);
        chk("R10 next frame passes", buf_we_o, 1);
        step(1, 4'd8, 9'h079, 1'b0, 1, 1);
        chk("R10 old state passes", buf_we_o, 1);
        step(1, 4'd8, 9'h07A, 1'b0, 0, 0);
        chk("R3 dropped after set", buf_we_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_pass_all();
        t_filter_on();
        t_auto_match();
        t_short_compare();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule